// File: doc/BRIEF.md
# Write-Completion Status Read Path

This block sits on the read side of a byte-alterable nonvolatile memory and tells the host, through ordinary reads, whether the internal programming cycle is still running. The write controller supplies a busy flag and the byte most recently written. While busy is high, every read returns status in place of array contents. Bit 7 carries the inverse of the written byte's bit 7, and bit 6 flips on each new read access. Once busy falls, reads return the array data unchanged and bit 6 holds its last value.

The output is gated by two active-low select inputs. Data is driven only while both are low, and it is reported through a drive-enable flag; an undriven bus reads as zero. A separate flag tells the host when it may issue the next write. That flag stays low while programming runs and for a programmable settling window after programming ends.

All inputs are sampled on the rising clock edge. Read data and the drive flag are registered, so they follow the strobes with one cycle of latency.

Top module: `wcs_status_read`

## Requirements
- R1: `bus_drive_o` is 1 in the cycle after an edge at which `ce_ni` and `oe_ni` were both sampled low, and 0 otherwise.
- R2: While `bus_drive_o` is 0, `bus_data_o` is all zeros.
- R3: During a read sampled with `busy_i` high, bit 7 of `bus_data_o` equals the inverse of bit 7 of `last_data_i`. No address is involved, so every location reports status.
- R4: With `busy_i` high, bit 6 of `bus_data_o` inverts at the start of each new read access, which is the first edge with both selects low after an edge without. Bit 6 holds constant for the rest of that access.
- R5: During a read sampled with `busy_i` high, bits 5..0 of `bus_data_o` equal bits 5..0 of `last_data_i`.
- R6: During a read sampled with `busy_i` low, `bus_data_o` equals `array_data_i` as sampled.
- R7: Read accesses made while `busy_i` is low do not advance the bit-6 state. The next busy read continues from the held value.
- R8: `write_ok_o` is 0 while `busy_i` is high. After `busy_i` falls, it stays 0 until HOLD_CYC rising edges with `busy_i` low have passed, and it is 1 from then on.
- R9: After reset, `bus_drive_o` is 0, `bus_data_o` is 0 and `write_ok_o` is 1. The bit-6 state starts at 0, so the first busy read returns bit 6 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| busy_i | input | 1 | Internal programming in progress |
| last_data_i | input | DW | Byte most recently written |
| array_data_i | input | DW | Array contents at the addressed location |
| bus_data_o | output | DW | Read data; zero when not driven |
| bus_drive_o | output | 1 | Output drive enable |
| write_ok_o | output | 1 | Next write may be issued |

## Verification
The main read path is tried with several patterns:
- Idle reads, which must pass array bytes through.
- Busy reads with different last-written bytes, so that an inverted bit 7 is distinguished from a passed-through bit 7 and the lower six bits are distinguished from array data.
- Interleaved idle and busy reads, which show whether idle accesses wrongly advance the toggle.

One held access lasts several cycles, which separates per-access toggling from per-cycle toggling. Each select is also raised alone, to confirm that the two gate independently. The settling window is probed one cycle before and one cycle at its end.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;

  typedef struct packed {
    logic active;
    logic start;
  } rd_evt_t;
endpackage

// File: rtl/wcs_strobe.sv
module wcs_strobe
  import wcs_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ce_ni,
  input  logic    oe_ni,
  output rd_evt_t evt_o
);
  logic act, act_q;

  assign act = ~ce_ni & ~oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end

  assign evt_o.active = act;
  assign evt_o.start  = act & ~act_q;
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic busy_i,
  output logic tog_o
);
  logic tog_q;

  // value seen by the access that starts this cycle
  assign tog_o = tog_q ^ (step_i & busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= tog_o;
  end
endmodule

// File: rtl/wcs_holdoff.sv
module wcs_holdoff #(
  parameter int unsigned HOLD_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD = HOLD_CYC[CW-1:0];

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (busy_i)           cnt_q <= LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end

  assign ok_o = (cnt_q == '0) & ~busy_i;
endmodule

// File: rtl/wcs_merge.sv
module wcs_merge #(
  parameter int unsigned DW   = 8,
  parameter int unsigned POLL = 7,
  parameter int unsigned TOG  = 6
) (
  input  logic          busy_i,
  input  logic          tog_i,
  input  logic [DW-1:0] last_data_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] data_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == POLL) begin : g_poll
      assign data_o[i] = busy_i ? ~last_data_i[i] : array_data_i[i];
    end else if (i == TOG) begin : g_tog
      assign data_o[i] = busy_i ? tog_i : array_data_i[i];
    end else begin : g_pass
      assign data_o[i] = busy_i ? last_data_i[i] : array_data_i[i];
    end
  end
endmodule

// File: rtl/wcs_status_read.sv
module wcs_status_read
  import wcs_pkg::*;
#(
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned HOLD_CYC = 2000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          busy_i,
  input  logic [DW-1:0] last_data_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_drive_o,
  output logic          write_ok_o
);
  rd_evt_t       evt;
  logic          tog;
  logic [DW-1:0] merged;
  logic [DW-1:0] data_q;
  logic          drive_q;

  wcs_strobe u_strobe (
    .clk_i (clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .evt_o(evt)
  );

  wcs_toggle u_toggle (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(evt.start), .busy_i(busy_i), .tog_o(tog)
  );

  wcs_merge #(.DW(DW), .POLL(POLL_BIT), .TOG(TOG_BIT)) u_merge (
    .busy_i(busy_i), .tog_i(tog), .last_data_i(last_data_i),
    .array_data_i(array_data_i), .data_o(merged)
  );

  wcs_holdoff #(.HOLD_CYC(HOLD_CYC)) u_holdoff (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .ok_o(write_ok_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q <= 1'b0;
      data_q  <= '0;
    end else begin
      drive_q <= evt.active;
      data_q  <= evt.active ? merged : '0;
    end
  end

  assign bus_drive_o = drive_q;
  assign bus_data_o  = data_q;
endmodule

// File: rtl/wcs_status_read_chk.sv
module wcs_status_read_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          busy_i,
  input logic [DW-1:0] last_data_i,
  input logic [DW-1:0] array_data_i,
  input logic [DW-1:0] bus_data_o,
  input logic          bus_drive_o,
  input logic          write_ok_o
);
  // R1
  drive_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_drive_o |-> $past(!ce_ni && !oe_ni));

  // R2
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_drive_o |-> (bus_data_o == '0));

  // R3
  poll_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_drive_o && $past(busy_i)) |-> (bus_data_o[7] == !$past(last_data_i[7])));

  // R4
  tog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_drive_o && $past(bus_drive_o) && $past(busy_i) && $past(busy_i, 2))
      |-> (bus_data_o[6] == $past(bus_data_o[6])));

  // R5
  low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_drive_o && $past(busy_i)) |-> (bus_data_o[5:0] == $past(last_data_i[5:0])));

  // R6
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_drive_o && !$past(busy_i)) |-> (bus_data_o == $past(array_data_i)));

  // R8
  settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> !write_ok_o);
endmodule

bind wcs_status_read wcs_status_read_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .busy_i(busy_i),
  .last_data_i(last_data_i), .array_data_i(array_data_i), .bus_data_o(bus_data_o),
  .bus_drive_o(bus_drive_o), .write_ok_o(write_ok_o)
);

// File: tb/tb_wcs_status_read.sv
`timescale 1ns/1ps
module tb_wcs_status_read;
  localparam int unsigned HOLD = 20;
  localparam int NROW = 7;
  // {busy, last_data, array_data, expected}
  localparam logic [24:0] VEC [NROW] = '{
    {1'b0, 8'h00, 8'h3C, 8'h3C},  // R6 idle pass
    {1'b1, 8'h5A, 8'hFF, 8'hDA},  // R3 R4 R5 first busy read, toggle=1
    {1'b1, 8'h5A, 8'hFF, 8'h9A},  // R4 toggle=0
    {1'b1, 8'h80, 8'h00, 8'h40},  // R3 bit7 inverted to 0, toggle=1
    {1'b0, 8'h11, 8'hA5, 8'hA5},  // R7 idle read, toggle held
    {1'b1, 8'hFF, 8'h00, 8'h3F},  // R7 resumes 1->0
    {1'b0, 8'hFF, 8'h00, 8'h00}   // R6
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [7:0] last_d = '0, arr_d = '0;
  logic [7:0] bus_d;
  logic drv, wok;
  int total = 0, bad = 0;
  logic tog_m;

  always #2.5 clk = ~clk;

  wcs_status_read #(.HOLD_CYC(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .busy_i(busy),
    .last_data_i(last_d), .array_data_i(arr_d), .bus_data_o(bus_d),
    .bus_drive_o(drv), .write_ok_o(wok)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic one_read(input string req, input logic [7:0] exp);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk({req, " drive"}, {7'd0, drv}, 8'h01);
    chk(req, bus_d, exp);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    chk("R2 released", {drv, 7'd0} | bus_d, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 drive", {7'd0, drv}, 8'h00);
    chk("R9 data", bus_d, 8'h00);
    chk("R9 write_ok", {7'd0, wok}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROW; i++) begin
      busy = VEC[i][24]; last_d = VEC[i][23:16]; arr_d = VEC[i][15:8];
      @(negedge clk);
      one_read($sformatf("R3-6 row%0d", i), VEC[i][7:0]);
    end
    tog_m = 1'b0;  // state after table

    // R1: only one select low
    busy = 1'b0; arr_d = 8'h77;
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    chk("R1 oe high", {7'd0, drv}, 8'h00);
    chk("R2 oe high", bus_d, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    chk("R1 ce high", {7'd0, drv}, 8'h00);
    chk("R2 ce high", bus_d, 8'h00);
    oe_n = 1'b1;

    // R4: held access, bit 6 fixed for whole access
    busy = 1'b1; last_d = 8'h00;
    @(negedge clk);
    tog_m = ~tog_m;
    ce_n = 1'b0; oe_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R4 held access", bus_d, {1'b1, tog_m, 6'h00});
    end
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    tog_m = ~tog_m;
    one_read("R4 next access", {1'b1, tog_m, 6'h00});

    // R8 write_ok during busy and settling window
    chk("R8 busy", {7'd0, wok}, 8'h00);
    busy = 1'b0;
    repeat (HOLD - 1) @(negedge clk);
    chk("R8 window end-1", {7'd0, wok}, 8'h00);
    @(negedge clk);
    chk("R8 window end", {7'd0, wok}, 8'h01);

    // R7: idle reads leave toggle alone
    arr_d = 8'hC3;
    one_read("R7 idle a", 8'hC3);
    one_read("R7 idle b", 8'hC3);
    busy = 1'b1; last_d = 8'h7F;
    @(negedge clk);
    tog_m = ~tog_m;
    one_read("R7 resume", {1'b1, tog_m, 6'h3F});
    busy = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule